// File: doc/BRIEF.md
# Transparent-Channel Event and Mask Register

This block collects status events from a serial channel running in transparent mode. The sources are receive and transmit clock glitches, a change in the carrier-sense level, completion of a graceful stop, transmit errors, a busy condition, and transmit and receive buffer events. Each event is held in a sticky bit of a 16-bit event register. A second 16-bit register holds the interrupt enables. Software reads both registers through a small synchronous port. It clears an event by writing a one to its bit. A single level interrupt request is raised while any event bit is set and also enabled.

The block contains two small pieces of event logic. A carrier-sense watcher flags either edge of the carrier-sense level while the recovery loop is enabled. A graceful-stop tracker reports completion at once when no frame is being sent. If a frame is in progress, it holds the request pending and reports completion at the end of that frame, once per command.

Bits are numbered from the most significant end: "position k" means vector index 15-k.

Top module: `tch_evt_regs`

## Requirements
- R1: Each source pulse sets its own event bit at the clock edge where it is sampled. The vector indices are: rx glitch 12 (0x1000), tx glitch 11 (0x0800), carrier change 10 (0x0400), stop complete 7 (0x0080), tx error 4 (0x0010), busy 2 (0x0004), tx buffer 1 (0x0002), rx buffer 0 (0x0001).
- R2: All other bits are reserved. They read as zero in both registers and can never be set, so the mask reads back at most 0x1C97.
- R3: Reset (synchronous, active high) clears both registers, the read data and the interrupt request.
- R4: A write to the event register (addr_i=0) clears every bit written as one. Bits written as zero keep their value.
- R5: If a source pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: irq_o equals the OR of (event AND mask), aligned with the current register contents. It stays high until every enabled set event is cleared, and disabled events never raise it.
- R7: A write with addr_i=1 loads the mask, with the reserved bits forced to zero.
- R8: The carrier-change bit is set on either edge of dpll_cs_i, but only while dpll_en_i is high. The first sample after reset is never treated as a change.
- R9: A stop command while tx_frame_active_i is low sets the stop-complete bit at that edge.
- R10: A stop command while tx_frame_active_i is high leaves the bit clear until the next tx_frame_end_i pulse, and then sets it. A later frame end with no new command sets nothing.
- R11: A read (sel_i=1, we_i=0) returns the register chosen by addr_i, as it stood before that edge, on rdata_o after the edge. rdata_o holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk_glitch_i | input | 1 | Receive clock glitch pulse |
| tx_clk_glitch_i | input | 1 | Transmit clock glitch pulse |
| dpll_en_i | input | 1 | Carrier recovery loop enabled |
| dpll_cs_i | input | 1 | Carrier-sense level from the recovery loop |
| stop_cmd_i | input | 1 | Graceful stop command pulse |
| tx_frame_active_i | input | 1 | A transmit frame is in progress |
| tx_frame_end_i | input | 1 | Transmit frame finished pulse |
| tx_err_i | input | 1 | Transmit error pulse |
| busy_i | input | 1 | Busy condition pulse |
| tx_buf_i | input | 1 | Transmit buffer event pulse |
| rx_buf_i | input | 1 | Receive buffer event pulse |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable (0 = read) |
| addr_i | input | 1 | 0 = event register, 1 = mask register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the deferred stop completion. It needs a command issued mid-frame, a delay, a frame end, and then a second frame end that must not set the bit again. Hitting this through random pulses alone is rare. A directed sequence drives the exact ordering. Random traffic then keeps frames opening and closing while commands, clears and mask writes land in arbitrary cycles. A bench model checks every cycle, including collisions of set and clear on the same bit.

// File: rtl/tch_evt_pkg.sv
package tch_evt_pkg;
  localparam int REG_W = 16;

  // field positions are given from the most significant end
  function automatic int idx_of(input int msb_pos);
    return REG_W - 1 - msb_pos;
  endfunction

  localparam int B_GLR = idx_of(3);
  localparam int B_GLT = idx_of(4);
  localparam int B_DCC = idx_of(5);
  localparam int B_GRA = idx_of(8);
  localparam int B_TXE = idx_of(11);
  localparam int B_BSY = idx_of(13);
  localparam int B_TXB = idx_of(14);
  localparam int B_RXB = idx_of(15);

  localparam logic [REG_W-1:0] EVT_VALID =
      (REG_W'(1) << B_GLR) | (REG_W'(1) << B_GLT) | (REG_W'(1) << B_DCC) |
      (REG_W'(1) << B_GRA) | (REG_W'(1) << B_TXE) | (REG_W'(1) << B_BSY) |
      (REG_W'(1) << B_TXB) | (REG_W'(1) << B_RXB);
endpackage

// File: rtl/tch_cs_watch.sv
module tch_cs_watch (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic cs_i,
  output logic chg_o
);
  logic cs_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cs_q     <= cs_i;
      primed_q <= 1'b1;
    end
  end

  // level tracked always so enabling the loop creates no false edge
  assign chg_o = primed_q & en_i & (cs_i ^ cs_q);
endmodule

// File: rtl/tch_stop_track.sv
module tch_stop_track (
  input  logic clk,
  input  logic rst,
  input  logic cmd_i,
  input  logic active_i,
  input  logic frame_end_i,
  output logic done_o,
  output logic pend_o
);
  logic pend_q;

  assign done_o = (cmd_i & ~active_i) | ((pend_q | cmd_i) & frame_end_i);

  always_ff @(posedge clk) begin
    if (rst)               pend_q <= 1'b0;
    else if (done_o)       pend_q <= 1'b0;
    else if (cmd_i & active_i) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/tch_evt_store.sv
module tch_evt_store #(
  parameter int               W     = 16,
  parameter logic [W-1:0]     VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] ev_next_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic q;
      // a set in the same cycle as a clear wins
      assign ev_next_o[i] = set_i[i] | (q & ~clr_i[i]);
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= ev_next_o[i];
      end
      assign ev_o[i] = q;
    end else begin : g_rsvd
      assign ev_next_o[i] = 1'b0;
      assign ev_o[i]      = 1'b0;
    end
  end
endmodule

// File: rtl/tch_evt_regs.sv
module tch_evt_regs
  import tch_evt_pkg::*;
#(
  parameter int               W     = REG_W,
  parameter logic [W-1:0]     VALID = EVT_VALID
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_clk_glitch_i,
  input  logic         tx_clk_glitch_i,
  input  logic         dpll_en_i,
  input  logic         dpll_cs_i,
  input  logic         stop_cmd_i,
  input  logic         tx_frame_active_i,
  input  logic         tx_frame_end_i,
  input  logic         tx_err_i,
  input  logic         busy_i,
  input  logic         tx_buf_i,
  input  logic         rx_buf_i,
  input  logic         sel_i,
  input  logic         we_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  logic         cs_chg;
  logic         stop_done;
  logic         stop_pend;
  logic [W-1:0] hw_set;
  logic [W-1:0] sw_clr;
  logic [W-1:0] ev_q;
  logic [W-1:0] ev_d;
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic [W-1:0] rdata_q;
  logic         irq_q;
  logic         wr_evt;
  logic         wr_msk;
  logic         rd_req;

  tch_cs_watch u_cs (
    .clk   (clk),
    .rst   (rst),
    .en_i  (dpll_en_i),
    .cs_i  (dpll_cs_i),
    .chg_o (cs_chg)
  );

  tch_stop_track u_stop (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (stop_cmd_i),
    .active_i    (tx_frame_active_i),
    .frame_end_i (tx_frame_end_i),
    .done_o      (stop_done),
    .pend_o      (stop_pend)
  );

  always_comb begin
    hw_set        = '0;
    hw_set[B_GLR] = rx_clk_glitch_i;
    hw_set[B_GLT] = tx_clk_glitch_i;
    hw_set[B_DCC] = cs_chg;
    hw_set[B_GRA] = stop_done;
    hw_set[B_TXE] = tx_err_i;
    hw_set[B_BSY] = busy_i;
    hw_set[B_TXB] = tx_buf_i;
    hw_set[B_RXB] = rx_buf_i;
  end

  assign wr_evt = sel_i & we_i & ~addr_i;
  assign wr_msk = sel_i & we_i & addr_i;
  assign rd_req = sel_i & ~we_i;
  assign sw_clr = wr_evt ? wdata_i : '0;
  assign mask_d = wr_msk ? (wdata_i & VALID) : mask_q;

  tch_evt_store #(.W(W), .VALID(VALID)) u_store (
    .clk       (clk),
    .rst       (rst),
    .set_i     (hw_set),
    .clr_i     (sw_clr),
    .ev_o      (ev_q),
    .ev_next_o (ev_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(ev_d & mask_d);
      if (rd_req) rdata_q <= addr_i ? mask_q : ev_q;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tch_evt_regs_chk.sv
module tch_evt_regs_chk
  import tch_evt_pkg::*;
#(
  parameter int           W     = REG_W,
  parameter logic [W-1:0] VALID = EVT_VALID
) (
  input logic         clk,
  input logic         rst,
  input logic         rx_clk_glitch_i,
  input logic         sel_i,
  input logic         we_i,
  input logic         addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic         irq_o,
  input logic [W-1:0] ev_q,
  input logic [W-1:0] mask_q,
  input logic         stop_pend
);
  assert_glitch_sets_R1: assert property (@(posedge clk) disable iff (rst)
    rx_clk_glitch_i |=> ev_q[B_GLR]);

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> (ev_q == '0) && (mask_q == '0) && !irq_o);

  assert_write_one_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_i && we_i && !addr_i && wdata_i[B_GLR] && !rx_clk_glitch_i) |=> !ev_q[B_GLR]);

  assert_irq_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(ev_q & mask_q));

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_i && we_i && addr_i) |=> mask_q == ($past(wdata_i) & VALID));

  assert_pending_fires_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_pend) |-> ev_q[B_GRA]);

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && !we_i) |=> $stable(rdata_o));
endmodule

bind tch_evt_regs tch_evt_regs_chk #(.W(W), .VALID(VALID)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .rx_clk_glitch_i (rx_clk_glitch_i),
  .sel_i           (sel_i),
  .we_i            (we_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .rdata_o         (rdata_o),
  .irq_o           (irq_o),
  .ev_q            (ev_q),
  .mask_q          (mask_q),
  .stop_pend       (stop_pend)
);

// File: tb/tb_tch_evt_regs.sv
module tb_tch_evt_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grx = 0, gtx = 0, den = 0, dcs = 0, cmd = 0, act = 0, fend = 0;
  logic txe = 0, bsy = 0, txb = 0, rxb = 0, sel = 0, we = 0, addr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  tch_evt_regs dut (
    .clk(clk), .rst(rst),
    .rx_clk_glitch_i(grx), .tx_clk_glitch_i(gtx),
    .dpll_en_i(den), .dpll_cs_i(dcs),
    .stop_cmd_i(cmd), .tx_frame_active_i(act), .tx_frame_end_i(fend),
    .tx_err_i(txe), .busy_i(bsy), .tx_buf_i(txb), .rx_buf_i(rxb),
    .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // bench model built from the requirements
  logic [15:0] m_ev, m_mk, m_rd;
  logic m_irq, m_csp, m_prm, m_pend;

  always @(posedge clk) begin
    logic [15:0] s, c, evn, mkn;
    logic gra;
    if (rst) begin
      m_ev = 0; m_mk = 0; m_rd = 0; m_irq = 0; m_csp = 0; m_prm = 0; m_pend = 0;
    end else begin
      gra = (cmd && !act) || ((m_pend || cmd) && fend);
      s = 0;
      s[12] = grx; s[11] = gtx; s[10] = m_prm && den && (dcs != m_csp);
      s[7] = gra; s[4] = txe; s[2] = bsy; s[1] = txb; s[0] = rxb;
      c = (sel && we && !addr) ? wdata : 16'h0;
      evn = ((m_ev & ~c) | s) & 16'h1C97;
      mkn = (sel && we && addr) ? (wdata & 16'h1C97) : m_mk;
      if (sel && !we) m_rd = addr ? m_mk : m_ev;
      if (gra) m_pend = 0; else if (cmd && act) m_pend = 1;
      m_ev = evn; m_mk = mkn; m_irq = |(evn & mkn);
      m_csp = dcs; m_prm = 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // cycle-by-cycle comparison against the model (R6, R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R11 rdata vs model", rdata, m_rd);
      chk("R6 irq vs model", {15'h0, irq}, {15'h0, m_irq});
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    grx = 0; gtx = 0; cmd = 0; fend = 0; txe = 0; bsy = 0; txb = 0; rxb = 0;
    sel = 0; we = 0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    sel = 1; we = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    sel = 1; we = 0; addr = a;
    @(posedge clk); @(negedge clk);
    v = rdata;
    sel = 0;
  endtask

  task automatic pulse(input int k);
    case (k)
      0: grx = 1; 1: gtx = 1; 2: txe = 1; 3: bsy = 1; 4: txb = 1; default: rxb = 1;
    endcase
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, held;
    logic [15:0] bits [6] = '{16'h1000, 16'h0800, 16'h0010, 16'h0004, 16'h0002, 16'h0001};
    void'($urandom(32'h0000_5EED));
    repeat (4) @(negedge clk);
    rst = 0;

    rd(0, v); chk("R3 event after reset", v, 16'h0);
    rd(1, v); chk("R3 mask after reset", v, 16'h0);
    chk("R3 irq after reset", {15'h0, irq}, 16'h0);

    wr(1, 16'hFFFF);
    rd(1, v); chk("R2 R7 mask reserved bits", v, 16'h1C97);

    for (int k = 0; k < 6; k++) begin
      pulse(k);
      rd(0, v); chk("R1 source bit position", v, bits[k]);
      chk("R6 irq raised", {15'h0, irq}, 16'h1);
      wr(0, ~bits[k]);
      rd(0, v); chk("R4 zero write keeps bit", v, bits[k]);
      wr(0, bits[k]);
      rd(0, v); chk("R4 one write clears bit", v, 16'h0);
      chk("R6 irq dropped", {15'h0, irq}, 16'h0);
    end

    // R5: set and clear collide
    gtx = 1; wr(0, 16'h0800);
    rd(0, v); chk("R5 set wins over clear", v, 16'h0800);
    wr(0, 16'hFFFF);

    // R6: hold until every enabled event cleared, disabled ignored
    wr(1, 16'h0003);
    txb = 1; rxb = 1; cyc();
    wr(0, 16'h0002);
    chk("R6 irq held by remaining bit", {15'h0, irq}, 16'h1);
    wr(0, 16'h0001);
    chk("R6 irq after all cleared", {15'h0, irq}, 16'h0);
    bsy = 1; cyc();
    rd(0, v); chk("R6 masked event recorded", v, 16'h0004);
    chk("R6 masked event no irq", {15'h0, irq}, 16'h0);
    wr(0, 16'hFFFF);

    // R8: carrier change
    den = 0; dcs = 1; cyc(); dcs = 0; cyc();
    rd(0, v); chk("R8 no change while disabled", v, 16'h0);
    den = 1; dcs = 1; cyc();
    rd(0, v); chk("R8 rising edge", v, 16'h0400);
    wr(0, 16'h0400);
    dcs = 0; cyc();
    rd(0, v); chk("R8 falling edge", v, 16'h0400);
    wr(0, 16'h0400); den = 0;

    // R9: immediate completion
    act = 0; cmd = 1; cyc();
    rd(0, v); chk("R9 stop with no frame", v, 16'h0080);
    wr(0, 16'h0080);

    // R10: deferred completion, once per command
    act = 1; cyc(); cmd = 1; cyc(); cyc(); cyc();
    rd(0, v); chk("R10 pending during frame", v, 16'h0);
    fend = 1; cyc(); act = 0;
    rd(0, v); chk("R10 set at frame end", v, 16'h0080);
    wr(0, 16'h0080);
    act = 1; cyc(); fend = 1; cyc(); act = 0;
    rd(0, v); chk("R10 no repeat without command", v, 16'h0);

    // R11: rdata holds when not reading
    wr(1, 16'h1C97);
    rd(1, held);
    wr(1, 16'h0);
    cyc(); cyc();
    chk("R11 rdata held", rdata, held);
    rd(1, v); chk("R11 read sees updated mask", v, 16'h0);

    // constrained random phase, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      grx = ($urandom % 16) == 0; gtx = ($urandom % 16) == 0;
      txe = ($urandom % 16) == 0; bsy = ($urandom % 16) == 0;
      txb = ($urandom % 8) == 0;  rxb = ($urandom % 8) == 0;
      if (($urandom % 40) == 0) den = ~den;
      if (($urandom % 12) == 0) dcs = ~dcs;
      cmd = ($urandom % 20) == 0;
      if (act && ($urandom % 6) == 0) fend = 1;
      sel = ($urandom % 3) == 0; we = $urandom % 2; addr = $urandom % 2;
      wdata = 16'($urandom);
      @(posedge clk); @(negedge clk);
      if (fend) act = 0; else if (!act && ($urandom % 5) == 0) act = 1;
      grx = 0; gtx = 0; cmd = 0; fend = 0; txe = 0; bsy = 0; txb = 0; rxb = 0;
      sel = 0; we = 0;
    end

    finish_run();
  end
endmodule